// File: doc/BRIEF.md
# Banked Internal Data Memory

This block is the 256-byte internal data store of a small 8-bit controller core. The core reaches it in one of four ways, chosen per access by a mode code:

- **Direct.** An absolute address. The low half is RAM. The high half goes out to a special-function-register (SFR) port.
- **Indirect.** The byte address is taken from a working register, and the whole RAM range is reachable this way.
- **Register number.** A 3-bit register number is relocated into one of four banks of eight working registers.
- **Bit.** Single-bit read, set, clear or complement on a bit-addressable window.

One address in the high half holds a status register kept inside the block, and two of its bits select the active register bank. The same high-half address therefore means different things by mode. A direct access reaches the SFR port (or the internal status register). An indirect access reaches a hidden upper 128 bytes of RAM that nothing else can touch.

Each access is presented for one cycle with `acc_valid`. Read results, including the old bit value of a bit operation, come back registered on `rd_data` with `rd_valid` in the next cycle. The SFR strobes are combinational in the cycle of the access, and `sfr_rdata` is sampled in that same cycle. The instruction decoder, the ALU and the peripheral registers themselves live outside the block.

Top module: `bank_dmem`

## Requirements
- R1: After synchronous reset, `rd_valid` is 0, `bank_sel` is 0 and the status register reads 0x00. RAM contents are undefined after reset.
- R2: Mode 0 (direct) with address 0x00–0x7F reads or writes RAM. Those bytes are the same bytes that an indirect access with that address reaches.
- R3: A direct access to 0x80–0xFF other than 0xD0 never touches RAM.
  - A write pulses `sfr_wr` with `sfr_addr` and `sfr_wdata`.
  - A read pulses `sfr_rd`, and `rd_data` returns the `sfr_rdata` value sampled in that cycle.
  - The two strobes are never high together.
- R4: Mode 1 (indirect) at a pointer value of 0x80–0xFF reaches the upper 128 bytes of RAM. It raises no SFR strobe and does not alter the status register.
- R5: Mode 2 (register number) reaches RAM byte `bank_sel*8 + acc_addr[2:0]`.
- R6: The status register is held in the block at direct address 0xD0.
  - A direct write there updates all 8 bits without any SFR strobe.
  - Its bits [4:3] drive `bank_sel`, which changes only on such a write.
  - The new bank applies from the next access.
- R7: An indirect access takes its 8-bit address from working register `acc_addr[2:0]` of the active bank.
- R8: Mode 3 (bit) uses bit address b = `acc_addr[6:0]`, which maps to byte 0x20 + (b>>3), bit (b & 7). `acc_addr[7]` is ignored in this mode.
- R9: The bit operation codes on `bit_op` are 0 = read, 1 = set, 2 = clear and 3 = complement.
  - Every bit operation returns the old bit on `rd_data[0]`, with zeros above it.
  - Set, clear and complement rewrite only the addressed bit, within the same cycle.
- R10: `rd_valid` rises the cycle after a read or bit operation and stays low after a write.
  - A write is visible to an access in the very next cycle.
  - A read in the same cycle as a write to the same byte returns the old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request for this cycle |
| acc_mode | input | 2 | 0 direct, 1 indirect, 2 register number, 3 bit |
| acc_write | input | 1 | Write when high (ignored in bit mode) |
| acc_addr | input | 8 | Direct address, register number or bit address |
| acc_wdata | input | 8 | Write data |
| bit_op | input | 2 | Bit operation code for bit mode |
| rd_valid | output | 1 | Registered read result valid |
| rd_data | output | 8 | Registered read result |
| sfr_addr | output | 8 | SFR port address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, sampled in the access cycle |
| bank_sel | output | 2 | Active register bank |

## Verification
The embedded assertions watch several properties on every cycle:
- direct high-half accesses never write RAM;
- indirect and register-number accesses never strobe the SFR port;
- the SFR strobes are mutually exclusive;
- the bank field moves only on a status write;
- each RAM or status write lands in the following cycle;
- a bit operation changes at most one bit.

Other behaviours need the bench's scenarios, because they depend on where data actually goes:
- that a hidden upper byte survives a direct write to the same address;
- that bank relocation and pointer indirection reach the right byte;
- that the bit mapping works at both window ends;
- that a bit operation returns the pre-write bit.

// File: rtl/bank_dmem_pkg.sv
package bank_dmem_pkg;

    localparam int DM_DW        = 8;
    localparam int DM_AW        = 8;
    localparam int DM_NBANK     = 4;
    localparam int DM_NREG      = 8;
    localparam int DM_BW        = $clog2(DM_NBANK);
    localparam int DM_RW        = $clog2(DM_NREG);
    localparam int DM_BIW       = $clog2(DM_DW);
    localparam logic [DM_AW-1:0] DM_BIT_BASE  = 8'h20;
    localparam logic [DM_AW-1:0] DM_STAT_ADDR = 8'hD0;
    localparam int DM_BANK_LSB  = 3;

    typedef enum logic [1:0] {
        DM_DIRECT   = 2'd0,
        DM_INDIRECT = 2'd1,
        DM_REGNUM   = 2'd2,
        DM_BIT      = 2'd3
    } dm_mode_e;

    typedef enum logic [1:0] {
        BOP_READ = 2'd0,
        BOP_SET  = 2'd1,
        BOP_CLR  = 2'd2,
        BOP_CPL  = 2'd3
    } bit_op_e;

    typedef enum logic [1:0] {
        TGT_RAM  = 2'd0,
        TGT_SFR  = 2'd1,
        TGT_STAT = 2'd2,
        TGT_BIT  = 2'd3
    } dm_tgt_e;

    typedef struct packed {
        dm_tgt_e             tgt;
        logic [DM_AW-1:0]    ram_addr;
        logic [DM_BIW-1:0]   bit_idx;
    } dm_route_t;

    function automatic logic [DM_DW-1:0] apply_bit_op(
        input logic [DM_DW-1:0]  byte_in,
        input logic [DM_BIW-1:0] idx,
        input bit_op_e           op
    );
        logic [DM_DW-1:0] mask;
        mask = {{(DM_DW-1){1'b0}}, 1'b1} << idx;
        case (op)
            BOP_SET: return byte_in | mask;
            BOP_CLR: return byte_in & ~mask;
            BOP_CPL: return byte_in ^ mask;
            default: return byte_in;
        endcase
    endfunction

endpackage

// File: rtl/bank_dmem_ram.sv
module bank_dmem_ram
    import bank_dmem_pkg::*;
#(
    parameter int DW    = DM_DW,
    parameter int AW    = DM_AW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ptr_addr,
    output logic [DW-1:0] ptr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // both read ports see pre-edge contents: a same-cycle write is not forwarded
    assign ptr_data = mem[ptr_addr];
    assign rd_data  = mem[rd_addr];

    // R10
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/bank_dmem_status.sv
module bank_dmem_status
    import bank_dmem_pkg::*;
#(
    parameter int DW       = DM_DW,
    parameter int BW       = DM_BW,
    parameter int BANK_LSB = DM_BANK_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] status,
    output logic [BW-1:0] bank
);
    logic [DW-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst)     status_q <= '0;
        else if (we) status_q <= wdata;
    end

    assign status = status_q;
    assign bank   = status_q[BANK_LSB +: BW];

    // R6
    stat_update_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> status == $past(wdata));

endmodule

// File: rtl/bank_dmem_route.sv
module bank_dmem_route
    import bank_dmem_pkg::*;
#(
    parameter int AW = DM_AW,
    parameter int BW = DM_BW,
    parameter int RW = DM_RW,
    parameter int DW = DM_DW,
    localparam int BIW   = $clog2(DW),
    localparam int BYW   = AW - 1 - BIW
) (
    input  dm_mode_e      mode,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] bank,
    output logic [AW-1:0] ptr_addr,
    input  logic [DW-1:0] ptr_data,
    output dm_route_t     route
);
    logic [AW-1:0] reg_addr;
    logic [BYW-1:0] bit_byte;

    assign reg_addr = AW'({bank, addr[RW-1:0]});
    assign ptr_addr = reg_addr;
    assign bit_byte = addr[AW-2:BIW];

    always_comb begin
        route.tgt      = TGT_RAM;
        route.ram_addr = addr;
        route.bit_idx  = '0;
        case (mode)
            DM_DIRECT: begin
                if (addr[AW-1]) begin
                    route.tgt = (addr == DM_STAT_ADDR) ? TGT_STAT : TGT_SFR;
                end
            end
            DM_INDIRECT: route.ram_addr = AW'(ptr_data);
            DM_REGNUM:   route.ram_addr = reg_addr;
            DM_BIT: begin
                route.tgt      = TGT_BIT;
                route.ram_addr = DM_BIT_BASE + AW'(bit_byte);
                route.bit_idx  = addr[BIW-1:0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bank_dmem_bitunit.sv
module bank_dmem_bitunit
    import bank_dmem_pkg::*;
#(
    parameter int DW = DM_DW,
    localparam int BIW = $clog2(DW)
) (
    input  logic [DW-1:0]  byte_in,
    input  logic [BIW-1:0] idx,
    input  bit_op_e        op,
    output logic [DW-1:0]  byte_out,
    output logic           old_bit
);
    assign byte_out = apply_bit_op(byte_in, idx, op);
    assign old_bit  = byte_in[idx];

    // R9
    always_comb begin
        one_bit_chk: assert ($countones(byte_out ^ byte_in) <= 1);
    end

endmodule

// File: rtl/bank_dmem.sv
module bank_dmem
    import bank_dmem_pkg::*;
#(
    parameter int DW = DM_DW,
    parameter int AW = DM_AW,
    parameter int BW = DM_BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [1:0]    acc_mode,
    input  logic          acc_write,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic [1:0]    bit_op,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] sfr_addr,
    output logic          sfr_rd,
    output logic          sfr_wr,
    output logic [DW-1:0] sfr_wdata,
    input  logic [DW-1:0] sfr_rdata,
    output logic [BW-1:0] bank_sel
);
    dm_mode_e      mode;
    bit_op_e       bop;
    dm_route_t     route;
    logic [AW-1:0] ptr_addr;
    logic [DW-1:0] ptr_data;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] bit_wbyte;
    logic          bit_old;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;
    logic          stat_we;
    logic [DW-1:0] status;
    logic [DW-1:0] rd_next;
    logic          rd_valid_q;
    logic [DW-1:0] rd_data_q;

    assign mode = dm_mode_e'(acc_mode);
    assign bop  = bit_op_e'(bit_op);

    bank_dmem_route #(.AW(AW), .BW(BW), .DW(DW)) u_route (
        .mode     (mode),
        .addr     (acc_addr),
        .bank     (bank_sel),
        .ptr_addr (ptr_addr),
        .ptr_data (ptr_data),
        .route    (route)
    );

    bank_dmem_ram #(.DW(DW), .AW(AW)) u_ram (
        .clk      (clk),
        .rst      (rst),
        .ptr_addr (ptr_addr),
        .ptr_data (ptr_data),
        .rd_addr  (route.ram_addr),
        .rd_data  (ram_rdata),
        .we       (ram_we),
        .waddr    (route.ram_addr),
        .wdata    (ram_wdata)
    );

    bank_dmem_bitunit #(.DW(DW)) u_bit (
        .byte_in  (ram_rdata),
        .idx      (route.bit_idx),
        .op       (bop),
        .byte_out (bit_wbyte),
        .old_bit  (bit_old)
    );

    bank_dmem_status #(.DW(DW), .BW(BW)) u_status (
        .clk   (clk),
        .rst   (rst),
        .we    (stat_we),
        .wdata (acc_wdata),
        .status(status),
        .bank  (bank_sel)
    );

    always_comb begin
        ram_we    = 1'b0;
        ram_wdata = acc_wdata;
        stat_we   = 1'b0;
        sfr_rd    = 1'b0;
        sfr_wr    = 1'b0;
        rd_next   = ram_rdata;
        if (acc_valid) begin
            case (route.tgt)
                TGT_RAM:  ram_we = acc_write;
                TGT_SFR: begin
                    sfr_wr = acc_write;
                    sfr_rd = ~acc_write;
                end
                TGT_STAT: stat_we = acc_write;
                TGT_BIT: begin
                    ram_we    = (bop != BOP_READ);
                    ram_wdata = bit_wbyte;
                end
                default: ;
            endcase
        end
        case (route.tgt)
            TGT_SFR:  rd_next = sfr_rdata;
            TGT_STAT: rd_next = status;
            TGT_BIT:  rd_next = {{(DW-1){1'b0}}, bit_old};
            default:  rd_next = ram_rdata;
        endcase
    end

    assign sfr_addr  = acc_addr;
    assign sfr_wdata = acc_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= acc_valid & (~acc_write | (route.tgt == TGT_BIT));
            if (acc_valid) rd_data_q <= rd_next;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (bank_sel == '0 && !rd_valid));

    // R3
    sfr_no_ram_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && mode == DM_DIRECT && acc_addr[AW-1]) |-> !ram_we);

    // R3
    sfr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sfr_rd, sfr_wr}));

    // R4
    ind_no_sfr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (mode == DM_INDIRECT || mode == DM_REGNUM)) |-> (!sfr_rd && !sfr_wr));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_we |=> $stable(bank_sel));

    // R10
    wr_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && mode != DM_BIT) |=> !rd_valid);

endmodule

// File: tb/bank_dmem_bench.sv
module bank_dmem_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic [1:0] acc_mode = 2'd0;
    logic       acc_write = 1'b0;
    logic [7:0] acc_addr = 8'h00;
    logic [7:0] acc_wdata = 8'h00;
    logic [1:0] bit_op = 2'd0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [7:0] sfr_addr;
    logic       sfr_rd;
    logic       sfr_wr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;
    logic [1:0] bank_sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic       s_rd, s_wr;
    logic [7:0] s_addr, s_wdata;
    logic       o_valid;
    logic [7:0] o_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sfr_rdata = sfr_addr ^ 8'h5A;

    bank_dmem u_bank_dmem (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_mode(acc_mode),
        .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .bit_op(bit_op), .rd_valid(rd_valid), .rd_data(rd_data),
        .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .bank_sel(bank_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] m, input logic w, input logic [7:0] a,
                       input logic [7:0] d, input logic [1:0] op);
        @(negedge clk);
        acc_valid = 1'b1; acc_mode = m; acc_write = w;
        acc_addr = a; acc_wdata = d; bit_op = op;
        #1;
        s_rd = sfr_rd; s_wr = sfr_wr; s_addr = sfr_addr; s_wdata = sfr_wdata;
        @(posedge clk);
        #1;
        o_valid = rd_valid; o_data = rd_data;
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R1 bank_sel", {6'd0, bank_sel}, 8'h00);
        acc(2'd0, 1'b0, 8'hD0, 8'h00, 2'd0);
        check("R1 status", o_data, 8'h00);
    endtask

    task automatic t_low();
        acc(2'd0, 1'b1, 8'h45, 8'hA5, 2'd0);
        acc(2'd0, 1'b0, 8'h45, 8'h00, 2'd0);
        check("R2 direct readback", o_data, 8'hA5);
        acc(2'd0, 1'b1, 8'h00, 8'h45, 2'd0);
        acc(2'd1, 1'b0, 8'h00, 8'h00, 2'd0);
        check("R2 R7 indirect same byte", o_data, 8'hA5);
        acc(2'd0, 1'b1, 8'h01, 8'h7F, 2'd0);
        acc(2'd1, 1'b1, 8'h01, 8'h3C, 2'd0);
        acc(2'd0, 1'b0, 8'h7F, 8'h00, 2'd0);
        check("R2 indirect write seen direct", o_data, 8'h3C);
    endtask

    task automatic t_upper();
        acc(2'd0, 1'b1, 8'h02, 8'h90, 2'd0);
        acc(2'd1, 1'b1, 8'h02, 8'h33, 2'd0);
        check("R4 no sfr strobe", {6'd0, s_rd, s_wr}, 8'h00);
        acc(2'd0, 1'b1, 8'h90, 8'hEE, 2'd0);
        check("R3 sfr_wr", {6'd0, s_rd, s_wr}, 8'h01);
        check("R3 sfr_addr", s_addr, 8'h90);
        check("R3 sfr_wdata", s_wdata, 8'hEE);
        acc(2'd1, 1'b0, 8'h02, 8'h00, 2'd0);
        check("R3 R4 hidden byte kept", o_data, 8'h33);
        acc(2'd0, 1'b0, 8'hA0, 8'h00, 2'd0);
        check("R3 sfr_rd", {6'd0, s_rd, s_wr}, 8'h02);
        check("R3 sfr read data", o_data, 8'hA0 ^ 8'h5A);
        acc(2'd0, 1'b1, 8'h02, 8'hD0, 2'd0);
        acc(2'd1, 1'b1, 8'h02, 8'h1F, 2'd0);
        check("R4 status untouched", {6'd0, bank_sel}, 8'h00);
        acc(2'd1, 1'b0, 8'h02, 8'h00, 2'd0);
        check("R4 hidden 0xD0", o_data, 8'h1F);
        acc(2'd0, 1'b0, 8'hD0, 8'h00, 2'd0);
        check("R4 status reads 0", o_data, 8'h00);
    endtask

    task automatic t_banks();
        for (int k = 0; k < 4; k++) acc(2'd0, 1'b1, 8'(k*8 + 5), 8'(8'h50 + k), 2'd0);
        for (int k = 3; k >= 0; k--) begin
            acc(2'd0, 1'b1, 8'hD0, 8'(k << 3) | 8'h41, 2'd0);
            check("R6 no sfr strobe on status", {6'd0, s_rd, s_wr}, 8'h00);
            check("R6 bank_sel", {6'd0, bank_sel}, 8'(k));
            acc(2'd2, 1'b0, 8'h05, 8'h00, 2'd0);
            check("R5 R6 regnum in bank", o_data, 8'(8'h50 + k));
        end
        acc(2'd0, 1'b1, 8'hD0, 8'h10, 2'd0);
        acc(2'd0, 1'b0, 8'hD0, 8'h00, 2'd0);
        check("R6 status readback", o_data, 8'h10);
        acc(2'd0, 1'b1, 8'h30, 8'h99, 2'd0);
        acc(2'd2, 1'b1, 8'h03, 8'h30, 2'd0);
        acc(2'd1, 1'b0, 8'h03, 8'h00, 2'd0);
        check("R7 pointer from bank 2", o_data, 8'h99);
        acc(2'd0, 1'b0, 8'h13, 8'h00, 2'd0);
        check("R5 bank2 r3 address", o_data, 8'h30);
        acc(2'd0, 1'b1, 8'hD0, 8'h00, 2'd0);
    endtask

    task automatic t_bits();
        for (int i = 0; i < 16; i++) acc(2'd0, 1'b1, 8'(8'h20 + i), 8'(8'h11 * i), 2'd0);
        acc(2'd3, 1'b0, 8'h00, 8'h00, 2'd0);
        check("R9 bit read", o_data, 8'h00);
        check("R10 valid after bit op", {7'd0, o_valid}, 8'h01);
        acc(2'd3, 1'b0, 8'h00, 8'h00, 2'd1);
        check("R9 set old bit", o_data, 8'h00);
        acc(2'd0, 1'b0, 8'h20, 8'h00, 2'd0);
        check("R8 R9 set byte 0x20", o_data, 8'h01);
        acc(2'd3, 1'b0, 8'h7F, 8'h00, 2'd2);
        check("R9 clear old bit", o_data, 8'h01);
        acc(2'd0, 1'b0, 8'h2F, 8'h00, 2'd0);
        check("R8 R9 clear bit 127", o_data, 8'h7F);
        acc(2'd3, 1'b0, 8'h4A, 8'h00, 2'd3);
        check("R9 cpl old 0", o_data, 8'h00);
        acc(2'd0, 1'b0, 8'h29, 8'h00, 2'd0);
        check("R8 R9 cpl byte", o_data, 8'h9D);
        acc(2'd3, 1'b0, 8'h4A, 8'h00, 2'd3);
        check("R9 cpl old 1", o_data, 8'h01);
        acc(2'd0, 1'b0, 8'h29, 8'h00, 2'd0);
        check("R9 cpl restored", o_data, 8'h99);
        acc(2'd3, 1'b1, 8'h93, 8'hFF, 2'd1);
        acc(2'd0, 1'b0, 8'h22, 8'h00, 2'd0);
        check("R8 top bit ignored", o_data, 8'h2A);
    endtask

    task automatic t_timing();
        acc(2'd0, 1'b1, 8'h50, 8'h12, 2'd0);
        check("R10 no valid after write", {7'd0, o_valid}, 8'h00);
        acc(2'd0, 1'b0, 8'h50, 8'h00, 2'd0);
        check("R10 valid after read", {7'd0, o_valid}, 8'h01);
        check("R10 back-to-back data", o_data, 8'h12);
        acc(2'd3, 1'b0, 8'h7F, 8'h00, 2'd1);
        check("R10 same-cycle old data", o_data, 8'h00);
    endtask

    initial begin
        t_reset();
        t_low();
        t_upper();
        t_banks();
        t_bits();
        t_timing();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule